// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches 32 external input lines and turns configured activity on them into one combined interrupt request. Every line owns a 4-bit trigger field, an unmask bit and a sticky pending flag. A raw input first passes through a two-stage synchronizer. The synchronized value is then compared with its previous sample, which yields rising, falling and both-edge events. The block can also detect a held high or low level.

Software reaches the controller through a plain 32-bit register port: address, write data, write strobe, read strobe and registered read data. An event sets the line's pending flag whether or not the line is unmasked. The interrupt output is the registered OR of all pending flags that are unmasked. An interrupt handler reads the pending word and scans its set bits to find the sources. It then writes the same value back, which clears all of those bits at once.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and the trigger words, the unmask word and the pending word all read 0.
- R2: The four trigger words at offsets 0x200, 0x204, 0x208 and 0x20C are readable and writable. Line n uses bits (n mod 8)*4 to (n mod 8)*4+3 of the word at 0x200 + 4*(n/8).
- R3: Trigger code 0 (rising) sets line n's pending bit on a 0-to-1 transition of the line only. Holding the line high does not set the bit again after it is cleared.
- R4: Trigger code 1 (falling) sets the pending bit on a 1-to-0 transition only.
- R5: Trigger code 2 (high level) sets the pending bit on every clock while the line is high. A clear therefore has no lasting effect until the line goes low.
- R6: Trigger code 3 (low level) sets the pending bit on every clock while the line is low.
- R7: Trigger code 4 (both edges) sets the pending bit on each transition in either direction.
- R8: Trigger codes 5 to 15 detect nothing. The pending bit stays 0 however the line toggles.
- R9: The pending word at 0x214 holds bit n for line n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Writing back a value just read clears exactly the bits that were read as set.
- R10: If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R11: The unmask word at 0x210 holds bit n for line n and is readable and writable. A pending bit sets whether or not its line is unmasked. `irq_o` equals the OR of (pending AND unmask) as it stood one clock earlier.
- R12: A read of any unmapped offset returns 0. A write to an unmapped offset changes no register.
- R13: A line change that is stable before clock edge k reaches the pending bit at edge k+2 and `irq_o` at edge k+3.
- R14: `rdata_o` is loaded only on a clock edge where `rd_i` is 1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | 32 | Raw external interrupt lines, asynchronous |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; data appears on rdata_o after the edge |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The trigger logic is tested with five input patterns:
- a single rising step,
- a single falling step,
- a level held across a clear,
- a level that is already present when its mode is written,
- a full high-low pulse.

The rising step separates edge detection from level detection, because it sets the pending bit once and a clear then sticks. The held level shows that level modes re-set the bit and that a set wins over a clear. The full pulse, run in both-edge mode, must set the bit on both transitions. Run in an unused code, the same pulse must set nothing. A step on a masked line, followed by a timed step on an unmasked one, separates the pending path from the interrupt path and fixes the exact cycle latency.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  localparam int unsigned CFG_OFS  = 32'h200;
  localparam int unsigned EN_OFS   = 32'h210;
  localparam int unsigned STAT_OFS = 32'h214;

  function automatic logic trig_hit(logic [MODE_W-1:0] mode, logic cur, logic prev);
    logic hit;
    case (mode)
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      TRIG_HIGH: hit = cur;
      TRIG_LOW:  hit = ~cur;
      TRIG_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  // previous synchronized sample for edge comparison
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pipe_q[STAGES-1];
  end

  assign cur_o  = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_LINES*MODE_W-1:0] mode_i,
  input  logic [NUM_LINES-1:0]        cur_i,
  input  logic [NUM_LINES-1:0]        prev_i,
  output logic [NUM_LINES-1:0]        evt_o
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign evt_o[n] = trig_hit(mode_i[n*MODE_W +: MODE_W], cur_i[n], prev_i[n]);
  end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [NUM_LINES-1:0]        evt_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_LINES*MODE_W-1:0] cfg_o,
  output logic [NUM_LINES-1:0]        en_o,
  output logic [NUM_LINES-1:0]        pend_o,
  output logic                        irq_o
);
  localparam int unsigned LINES_PER_WORD = DATA_W / MODE_W;
  localparam int unsigned CFG_WORDS      = NUM_LINES / LINES_PER_WORD;
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(EN_OFS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

  logic [CFG_WORDS-1:0][DATA_W-1:0] cfg_q;
  logic [CFG_WORDS-1:0]             cfg_hit;
  logic [NUM_LINES-1:0]             en_q, pend_q, clr;
  logic                             en_hit, stat_hit, irq_q;
  logic [DATA_W-1:0]                rd_mux, rdata_q;

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
    assign cfg_hit[w] = (addr_i == ADDR_W'(CFG_OFS + 4 * w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cfg_q[w] <= '0;
      else if (wr_i && cfg_hit[w]) cfg_q[w] <= wdata_i;
    end
  end

  assign en_hit   = (addr_i == EN_ADDR);
  assign stat_hit = (addr_i == STAT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             en_q <= '0;
    else if (wr_i && en_hit) en_q <= wdata_i[NUM_LINES-1:0];
  end

  // write-one-to-clear; a same-cycle event wins
  assign clr = (wr_i && stat_hit) ? wdata_i[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_q & en_q);
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (cfg_hit[w]) rd_mux = cfg_q[w];
    end
    if (en_hit)   rd_mux = DATA_W'(en_q);
    if (stat_hit) rd_mux = DATA_W'(pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign cfg_o   = cfg_q;
  assign en_o    = en_q;
  assign pend_o  = pend_q;
  assign irq_o   = irq_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0]        cur, prev, evt, en, pend;
  logic [NUM_LINES*MODE_W-1:0] cfg_flat;

  pin_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (lines_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  pin_irq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .mode_i (cfg_flat),
    .cur_i  (cur),
    .prev_i (prev),
    .evt_o  (evt)
  );

  pin_irq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .evt_i   (evt),
    .rdata_o (rdata_o),
    .cfg_o   (cfg_flat),
    .en_o    (en),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_i,
  input logic                        rd_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [DATA_W-1:0]           rdata_o,
  input logic                        irq_o,
  input logic [NUM_LINES-1:0]        pend_i,
  input logic [NUM_LINES-1:0]        en_i,
  input logic [NUM_LINES-1:0]        evt_i,
  input logic [NUM_LINES*MODE_W-1:0] cfg_i
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

  logic [NUM_LINES-1:0] valid_mode;
  always_comb begin
    for (int n = 0; n < NUM_LINES; n++)
      valid_mode[n] = (cfg_i[n*MODE_W +: MODE_W] <= MODE_W'(TRIG_BOTH));
  end

  // R8
  a_r8_unused_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ~|(evt_i & ~valid_mode));

  // R3
  a_r3_set_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ~|(pend_i & ~$past(pend_i) & ~$past(evt_i)));

  // R9
  a_r9_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_i) & ~pend_i)) |-> ($past(wr_i) && ($past(addr_i) == STAT_ADDR)));

  // R10
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ~|($past(evt_i) & ~pend_i));

  // R11
  a_r11_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(pend_i & en_i))));

  // R14
  a_r14_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_i  (pend),
  .en_i    (en),
  .evt_i   (evt),
  .cfg_i   (cfg_flat)
);

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] cfg_m [4];

  always #5 clk = ~clk;

  pin_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(int line, logic [3:0] m);
    cfg_m[line/8][(line%8)*4 +: 4] = m;
    bus_wr(12'(32'h200 + 4 * (line / 8)), cfg_m[line/8]);
  endtask

  task automatic quiesce();
    for (int w = 0; w < 4; w++) begin
      cfg_m[w] = 32'hFFFF_FFFF;
      bus_wr(12'(32'h200 + 4 * w), cfg_m[w]);
    end
    @(negedge clk); lines = '0;
    settle();
    bus_wr(12'h214, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int w = 0; w < 4; w++) begin
      bus_rd(12'(32'h200 + 4 * w), d);
      check("R1 cfg", d, 32'h0);
    end
    bus_rd(12'h210, d); check("R1 enable", d, 32'h0);
    bus_rd(12'h214, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    logic [31:0] pat [4];
    pat[0] = 32'h1234_0A5F; pat[1] = 32'hCAFE_F00D;
    pat[2] = 32'h8765_4321; pat[3] = 32'hFEED_BEEF;
    for (int w = 0; w < 4; w++) bus_wr(12'(32'h200 + 4 * w), pat[w]);
    for (int w = 0; w < 4; w++) begin
      bus_rd(12'(32'h200 + 4 * w), d);
      check("R2 cfg readback", d, pat[w]);
    end
    quiesce();
    // line 13 falling: word 1, bits 23:20
    set_mode(13, 4'd1);
    bus_rd(12'h204, d); check("R2 field line13", d, 32'hFF1F_FFFF);
    @(negedge clk); lines[13] = 1'b1; settle();
    bus_rd(12'h214, d); check("R2 line13 no rise", d, 32'h0);
    @(negedge clk); lines[13] = 1'b0; settle();
    bus_rd(12'h214, d); check("R2 line13 fall", d, 32'h0000_2000);
    quiesce();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_mode(0, 4'd0);
    @(negedge clk); lines[0] = 1'b1; settle();
    bus_rd(12'h214, d); check("R3 rise sets", d, 32'h1);
    bus_wr(12'h214, 32'h1); settle();
    bus_rd(12'h214, d); check("R3 held high no reset", d, 32'h0);
    @(negedge clk); lines[0] = 1'b0; settle();
    bus_rd(12'h214, d); check("R3 fall ignored", d, 32'h0);
    quiesce();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_mode(5, 4'd1);
    @(negedge clk); lines[5] = 1'b1; settle();
    bus_rd(12'h214, d); check("R4 rise ignored", d, 32'h0);
    @(negedge clk); lines[5] = 1'b0; settle();
    bus_rd(12'h214, d); check("R4 fall sets", d, 32'h20);
    quiesce();
  endtask

  task automatic t_high();
    logic [31:0] d;
    set_mode(7, 4'd2); settle();
    bus_rd(12'h214, d); check("R5 low no event", d, 32'h0);
    @(negedge clk); lines[7] = 1'b1; settle();
    bus_rd(12'h214, d); check("R5 high sets", d, 32'h80);
    bus_wr(12'h214, 32'h80);
    bus_rd(12'h214, d); check("R10 held level beats clear", d, 32'h80);
    @(negedge clk); lines[7] = 1'b0; settle();
    bus_wr(12'h214, 32'h80);
    bus_rd(12'h214, d); check("R5 clear sticks after release", d, 32'h0);
    quiesce();
  endtask

  task automatic t_low();
    logic [31:0] d;
    set_mode(9, 4'd3); settle();
    bus_rd(12'h214, d); check("R6 low sets", d, 32'h200);
    @(negedge clk); lines[9] = 1'b1; settle();
    bus_wr(12'h214, 32'h200);
    bus_rd(12'h214, d); check("R6 clear sticks when high", d, 32'h0);
    quiesce();
  endtask

  task automatic t_both();
    logic [31:0] d;
    set_mode(20, 4'd4);
    @(negedge clk); lines[20] = 1'b1; settle();
    bus_rd(12'h214, d); check("R7 rise sets", d, 32'h0010_0000);
    bus_wr(12'h214, 32'h0010_0000); settle();
    bus_rd(12'h214, d); check("R7 stable no event", d, 32'h0);
    @(negedge clk); lines[20] = 1'b0; settle();
    bus_rd(12'h214, d); check("R7 fall sets", d, 32'h0010_0000);
    quiesce();
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    for (int m = 5; m < 16; m++) begin
      set_mode(3, 4'(m));
      @(negedge clk); lines[3] = 1'b1; settle();
      @(negedge clk); lines[3] = 1'b0; settle();
    end
    bus_wr(12'h210, 32'hFFFF_FFFF);
    bus_rd(12'h214, d); check("R8 unused codes quiet", d, 32'h0);
    check("R8 no irq", {31'b0, irq}, 32'h0);
    bus_wr(12'h210, 32'h0);
    quiesce();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    set_mode(0, 4'd0); set_mode(20, 4'd4); set_mode(31, 4'd0);
    @(negedge clk); lines[0] = 1'b1; lines[20] = 1'b1; lines[31] = 1'b1; settle();
    bus_rd(12'h214, d); check("R9 both set", d, 32'h8010_0001);
    bus_wr(12'h214, 32'h1);
    bus_rd(12'h214, d); check("R9 one bit cleared", d, 32'h8010_0000);
    bus_wr(12'h214, 32'h0);
    bus_rd(12'h214, d); check("R9 zero write no effect", d, 32'h8010_0000);
    bus_wr(12'h214, d);
    bus_rd(12'h214, d); check("R9 write-back clears all", d, 32'h0);
    quiesce();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    set_mode(0, 4'd0);
    @(negedge clk); lines[0] = 1'b1; settle();
    bus_rd(12'h214, d); check("R11 masked line pends", d, 32'h1);
    check("R11 masked no irq", {31'b0, irq}, 32'h0);
    bus_wr(12'h210, 32'h1);
    @(negedge clk);
    check("R11 irq after unmask", {31'b0, irq}, 32'h1);
    bus_rd(12'h210, d); check("R11 enable readback", d, 32'h1);
    bus_wr(12'h214, 32'h1);
    @(negedge clk);
    check("R11 irq drops on clear", {31'b0, irq}, 32'h0);
    @(negedge clk); lines[0] = 1'b0; settle();
    // timed step
    @(negedge clk); lines[0] = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(12'h214, d); check("R13 pending after two edges", d, 32'h1);
    check("R13 irq one edge later", {31'b0, irq}, 32'h1);
    bus_wr(12'h214, 32'h1);
    @(negedge clk); lines[0] = 1'b0; settle();
    @(negedge clk); lines[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 irq not early", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R13 irq on time", {31'b0, irq}, 32'h1);
    bus_wr(12'h210, 32'h0);
    quiesce();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(12'h210, 32'h0000_00F0);
    bus_wr(12'h218, 32'hFFFF_FFFF);
    bus_wr(12'h100, 32'hFFFF_FFFF);
    bus_wr(12'h201, 32'h0);
    bus_rd(12'h218, d); check("R12 unmapped read 0x218", d, 32'h0);
    bus_rd(12'h000, d); check("R12 unmapped read 0x000", d, 32'h0);
    bus_rd(12'h210, d); check("R12 enable untouched", d, 32'h0000_00F0);
    bus_rd(12'h200, d); check("R12 cfg untouched", d, 32'hFFFF_FFFF);
    bus_rd(12'h214, d); check("R12 status untouched", d, 32'h0);
    // R14: no read strobe, data holds
    repeat (3) @(negedge clk);
    check("R14 rdata holds", rdata, 32'h0);
    bus_wr(12'h210, 32'h0);
  endtask

  initial begin
    for (int w = 0; w < 4; w++) cfg_m[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_rise();
    t_fall();
    t_high();
    t_low();
    t_both();
    t_invalid();
    t_w1c();
    t_enable();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule